// File: doc/BRIEF.md
# Oversampled Serial Receive Framer

This block turns an asynchronous serial input into received characters. A free-running oversampling tick, sixteen or eight per bit time as selected by an input, sets its timing. The line first passes through a two-stage synchronizer. A falling edge on the synchronized line arms a tick counter. Half a bit time later the framer looks at the line again. If the line has gone high, the event was a glitch and the framer goes back to idle. If the line is still low, the framer samples every data, parity and stop bit at its own centre and shifts the data bits into an 8-bit register.

After the last stop bit is sampled, the framer raises a one-clock valid strobe. With the strobe it presents the right-aligned character and three error tags: parity error, framing error and line break. Word length (5 to 8 bits), parity use, parity sense and the number of stop bits are static configuration inputs. The framer has no buffering, no interrupt logic and no host access. A receive FIFO or a host interface sits downstream of it.

Top module: `rx_framer`

## Requirements
- R1: While reset is asserted and in the first clock after reset is released, rxValid is 0 and rxData, rxParErr, rxFrameErr and rxBreak are all 0.
- R2: rxIn passes through two flops before edge detection. A falling edge starts a tick count. The line is checked after OSR_HI/2 ticks (8) when osr8x=0, or after OSR_LO/2 ticks (4) when osr8x=1. If the line is high at that point, no character is produced and the framer returns to idle.
- R3: Data bits arrive least significant bit first. There are 5+wordLen of them (wordLen 0..3 gives 5..8 bits). rxData holds them right-aligned, and every bit above the word length is 0.
- R4: When parEn=1, one parity bit follows the data. The expected parity bit is the XOR of the data bits, inverted when parOdd=1. rxParErr is 1 exactly when the received parity bit differs from the expected one. When parEn=0, no parity bit is taken and rxParErr is 0.
- R5: rxFrameErr is 1 when the first stop bit is sampled low. When stop2=1 a second stop bit is also sampled, and rxFrameErr is also set when that second bit is low.
- R6: rxBreak is 1 when all data bits, the parity bit (if enabled) and the first stop bit are sampled low. A break character reports rxData=0 and rxFrameErr=1.
- R7: After each character the framer accepts a new start only once the line has been seen high. A line held low after a break yields exactly one character.
- R8: rxValid is high for exactly one clock per character. rxData and the three tags change only in that clock and hold their values in between.
- R9: The bit timing advances only on clocks with tickEn=1. One bit time is 16 ticks when osr8x=0 and 8 ticks when osr8x=1, whatever the spacing of the ticks.
- R10: A start bit may follow the last stop bit with no idle time, and consecutive characters are each received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Oversampling tick, one clock wide |
| osr8x | input | 1 | 1: eight ticks per bit, 0: sixteen ticks per bit |
| wordLen | input | 2 | Data bits minus five |
| parEn | input | 1 | Parity bit present |
| parOdd | input | 1 | 1: odd parity, 0: even parity |
| stop2 | input | 1 | Two stop bits |
| rxIn | input | 1 | Asynchronous serial line, idle high |
| rxValid | output | 1 | One-clock strobe: new character |
| rxData | output | DATA_W | Received character, right-aligned |
| rxParErr | output | 1 | Parity error tag |
| rxFrameErr | output | 1 | Framing error tag |
| rxBreak | output | 1 | Line break tag |

## Verification
The bench builds the framer with its defaults: an 8-bit register, a 5-bit minimum word, and 16 or 8 ticks per bit. These small values let it cover the whole configuration space, all 48 combinations of ratio, word length, parity mode and stop count. Each combination gets several data patterns plus parity-error, framing-error and break frames. Every 5-bit value is sent back-to-back. Start pulses shorter and longer than half a bit in each ratio show that the mid-bit point moves with the ratio, and a slower tick spacing confirms that timing follows the tick alone.

// File: rtl/rxfr_pkg.sv
package rxfr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2,
    ST_EMIT,
    ST_WAITHI
  } frameState_t;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic clear;
    logic shiftData;
    logic capPar;
    logic capStop1;
    logic capStop2;
    logic emit;
  } frameStrobe_t;

endpackage

// File: rtl/rxfr_ctrl.sv
module rxfr_ctrl
  import rxfr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  parameter int OSR_HI   = 16,
  parameter int OSR_LO   = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic         osr8x,
  input  logic [1:0]   wordLen,
  input  logic         parEn,
  input  logic         stop2,
  input  logic         rxBit,
  input  logic         rxFall,
  output frameStrobe_t strobe
);

  localparam int CW = $clog2(OSR_HI);
  localparam int BW = $clog2(DATA_W);

  frameState_t state, stateNext;
  logic [CW-1:0] tickCnt, tickCntNext;
  logic [BW-1:0] bitCnt, bitCntNext;

  logic [CW-1:0] fullLast, halfLast;
  logic [BW-1:0] lastIdx;
  logic          atFull;

  assign fullLast = osr8x ? CW'(OSR_LO - 1) : CW'(OSR_HI - 1);
  assign halfLast = osr8x ? CW'(OSR_LO / 2 - 1) : CW'(OSR_HI / 2 - 1);
  assign lastIdx  = BW'(MIN_BITS - 1) + BW'(wordLen);
  assign atFull   = tickEn && (tickCnt == fullLast);

  always_comb begin
    stateNext   = state;
    tickCntNext = tickCnt;
    bitCntNext  = bitCnt;
    strobe      = '0;
    // bit-period states share one counting rule
    if (tickEn && state inside {ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2})
      tickCntNext = tickCnt + CW'(1);
    unique case (state)
      ST_IDLE: begin
        if (rxFall) begin
          stateNext   = ST_START;
          tickCntNext = '0;
        end
      end
      ST_START: begin
        if (tickEn && tickCnt == halfLast) begin
          tickCntNext = '0;
          if (!rxBit) begin
            stateNext    = ST_DATA;
            bitCntNext   = '0;
            strobe.clear = 1'b1;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      ST_DATA: begin
        if (atFull) begin
          tickCntNext      = '0;
          strobe.shiftData = 1'b1;
          if (bitCnt == lastIdx) begin
            bitCntNext = '0;
            stateNext  = parEn ? ST_PAR : ST_STOP1;
          end else begin
            bitCntNext = bitCnt + BW'(1);
          end
        end
      end
      ST_PAR: begin
        if (atFull) begin
          tickCntNext   = '0;
          strobe.capPar = 1'b1;
          stateNext     = ST_STOP1;
        end
      end
      ST_STOP1: begin
        if (atFull) begin
          tickCntNext     = '0;
          strobe.capStop1 = 1'b1;
          stateNext       = stop2 ? ST_STOP2 : ST_EMIT;
        end
      end
      ST_STOP2: begin
        if (atFull) begin
          tickCntNext     = '0;
          strobe.capStop2 = 1'b1;
          stateNext       = ST_EMIT;
        end
      end
      ST_EMIT: begin
        strobe.emit = 1'b1;
        stateNext   = ST_WAITHI;
      end
      ST_WAITHI: begin
        if (rxBit) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      state   <= stateNext;
      tickCnt <= tickCntNext;
      bitCnt  <= bitCntNext;
    end
  end

endmodule

// File: rtl/rxfr_datapath.sv
module rxfr_datapath
  import rxfr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  frameStrobe_t      strobe,
  input  logic [1:0]        wordLen,
  input  logic              parEn,
  input  logic              parOdd,
  input  logic              stop2,
  output logic              rxBit,
  output logic              rxFall,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              rxParErr,
  output logic              rxFrameErr,
  output logic              rxBreak
);

  logic [1:0]        syncQ;
  logic              prevBit;
  logic [DATA_W-1:0] shiftReg;
  logic              parBit, stop1Bit, stop2Bit;

  logic [DATA_W-1:0] aligned;
  logic              parExp, parErrNow, frameErrNow, breakNow;
  int                dropBits;

  // two-flop synchronizer followed by a history flop for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '1;
      prevBit <= 1'b1;
    end else begin
      syncQ   <= {syncQ[0], rxIn};
      prevBit <= syncQ[1];
    end
  end

  assign rxBit  = syncQ[1];
  assign rxFall = prevBit & ~syncQ[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      stop1Bit <= 1'b1;
      stop2Bit <= 1'b1;
    end else begin
      if (strobe.clear) begin
        shiftReg <= '0;
        parBit   <= 1'b0;
        stop1Bit <= 1'b1;
        stop2Bit <= 1'b1;
      end
      if (strobe.shiftData) shiftReg <= {rxBit, shiftReg[DATA_W-1:1]};
      if (strobe.capPar)    parBit   <= rxBit;
      if (strobe.capStop1)  stop1Bit <= rxBit;
      if (strobe.capStop2)  stop2Bit <= rxBit;
    end
  end

  always_comb begin
    dropBits    = DATA_W - MIN_BITS - int'(wordLen);
    aligned     = shiftReg >> dropBits;
    parExp      = (^aligned) ^ parOdd;
    parErrNow   = parEn & (parBit != parExp);
    frameErrNow = ~stop1Bit | (stop2 & ~stop2Bit);
    breakNow    = (aligned == '0) & (~parEn | ~parBit) & ~stop1Bit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxValid    <= 1'b0;
      rxData     <= '0;
      rxParErr   <= 1'b0;
      rxFrameErr <= 1'b0;
      rxBreak    <= 1'b0;
    end else begin
      rxValid <= strobe.emit;
      if (strobe.emit) begin
        rxData     <= aligned;
        rxParErr   <= parErrNow;
        rxFrameErr <= frameErrNow;
        rxBreak    <= breakNow;
      end
    end
  end

endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import rxfr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  parameter int OSR_HI   = 16,
  parameter int OSR_LO   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              osr8x,
  input  logic [1:0]        wordLen,
  input  logic              parEn,
  input  logic              parOdd,
  input  logic              stop2,
  input  logic              rxIn,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              rxParErr,
  output logic              rxFrameErr,
  output logic              rxBreak
);

  frameStrobe_t strobe;
  logic         rxBit, rxFall;

  rxfr_ctrl #(
    .DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .OSR_HI(OSR_HI), .OSR_LO(OSR_LO)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .osr8x(osr8x),
    .wordLen(wordLen), .parEn(parEn), .stop2(stop2),
    .rxBit(rxBit), .rxFall(rxFall), .strobe(strobe)
  );

  rxfr_datapath #(
    .DATA_W(DATA_W), .MIN_BITS(MIN_BITS)
  ) i_dp (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .strobe(strobe),
    .wordLen(wordLen), .parEn(parEn), .parOdd(parOdd), .stop2(stop2),
    .rxBit(rxBit), .rxFall(rxFall), .rxValid(rxValid), .rxData(rxData),
    .rxParErr(rxParErr), .rxFrameErr(rxFrameErr), .rxBreak(rxBreak)
  );

endmodule

// File: rtl/rxfr_checker.sv
module rxfr_checker #(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        wordLen,
  input logic              parEn,
  input logic              rxValid,
  input logic [DATA_W-1:0] rxData,
  input logic              rxParErr,
  input logic              rxFrameErr,
  input logic              rxBreak
);

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  p_hold_outputs_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> $stable({rxData, rxParErr, rxFrameErr, rxBreak}));

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> ((rxData >> (MIN_BITS + int'(wordLen))) == '0));

  p_no_parity_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !parEn) |-> !rxParErr);

  p_break_frame_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxBreak) |-> (rxData == '0 && rxFrameErr));

endmodule

bind rx_framer rxfr_checker #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS)) u_rxfr_checker (.*);

// File: tb/test_rx_framer.sv
module test_rx_framer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       osr8x = 1'b0;
  logic [1:0] wordLen = 2'd3;
  logic       parEn = 1'b0;
  logic       parOdd = 1'b0;
  logic       stop2 = 1'b0;
  logic       rxIn = 1'b1;

  logic       rxValid, rxParErr, rxFrameErr, rxBreak;
  logic [7:0] rxData;

  int errors = 0;
  int checks = 0;
  int tickDiv = 2;
  int divCnt = 0;
  int validCount = 0;
  bit timedOut = 1'b0;
  logic [7:0] capData [1024];
  logic [2:0] capTags [1024];

  rx_framer i_rx_framer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .osr8x(osr8x), .wordLen(wordLen),
    .parEn(parEn), .parOdd(parOdd), .stop2(stop2), .rxIn(rxIn),
    .rxValid(rxValid), .rxData(rxData), .rxParErr(rxParErr),
    .rxFrameErr(rxFrameErr), .rxBreak(rxBreak)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (divCnt >= tickDiv - 1) begin
      divCnt <= 0;
      tickEn <= 1'b1;
    end else begin
      divCnt <= divCnt + 1;
      tickEn <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rxValid) begin
      if (validCount < 1024) begin
        capData[validCount] <= rxData;
        capTags[validCount] <= {rxParErr, rxFrameErr, rxBreak};
      end
      validCount <= validCount + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bitClk();
    return (osr8x ? 8 : 16) * tickDiv;
  endfunction

  task automatic holdLine(input logic v, input int n);
    rxIn = v;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] maskOf();
    return 8'((16'd1 << (5 + wordLen)) - 16'd1);
  endfunction

  function automatic logic parBitOf(input logic [7:0] d, input logic corrupt);
    return (^(d & maskOf())) ^ parOdd ^ corrupt;
  endfunction

  // expected {data, parErr, frameErr, break}
  function automatic logic [10:0] expected(input logic [7:0] d, input logic corrupt,
                                           input logic s1, input logic s2);
    logic [7:0] dm;
    logic pb, pe, fe, br;
    dm = d & maskOf();
    pb = parBitOf(d, corrupt);
    pe = parEn & corrupt;
    fe = !s1 || (stop2 && !s2);
    br = (dm == 8'd0) && (!parEn || !pb) && !s1;
    return {dm, pe, fe, br};
  endfunction

  task automatic sendFrame(input logic [7:0] d, input logic corrupt,
                           input logic s1, input logic s2, input int idleClk);
    int bc;
    bc = bitClk();
    holdLine(1'b0, bc);
    for (int i = 0; i < 5 + int'(wordLen); i++) holdLine(d[i], bc);
    if (parEn) holdLine(parBitOf(d, corrupt), bc);
    holdLine(s1, bc);
    if (stop2) holdLine(s2, bc);
    rxIn = 1'b1;
    if (idleClk > 0) holdLine(1'b1, idleClk);
  endtask

  task automatic checkAt(input int idx, input logic [7:0] d, input logic corrupt,
                         input logic s1, input logic s2, input string req);
    logic [10:0] e;
    e = expected(d, corrupt, s1, s2);
    chk({req, " data"}, 32'(capData[idx]), 32'(e[10:3]));
    chk({req, " tags"}, 32'(capTags[idx]), 32'(e[2:0]));
  endtask

  task automatic frameCheck(input logic [7:0] d, input logic corrupt,
                            input logic s1, input logic s2, input string req);
    int idx;
    idx = validCount;
    sendFrame(d, corrupt, s1, s2, bitClk() / 2);
    #1;
    chk({req, " R8 one pulse"}, 32'(validCount), 32'(idx + 1));
    checkAt(idx, d, corrupt, s1, s2, req);
  endtask

  task automatic breakCheck();
    int idx;
    idx = validCount;
    sendFrame(8'h00, parOdd, 1'b0, 1'b0, 0);
    holdLine(1'b0, 2 * bitClk());
    holdLine(1'b1, bitClk());
    #1;
    chk("R7 single char on held break", 32'(validCount), 32'(idx + 1));
    checkAt(idx, 8'h00, parOdd, 1'b0, 1'b0, "R6 break");
  endtask

  task automatic startPulse(input int lowTicks, input bit accept, input string req);
    int idx;
    idx = validCount;
    holdLine(1'b0, lowTicks * tickDiv);
    holdLine(1'b1, 12 * bitClk());
    #1;
    chk(req, 32'(validCount), 32'(idx + (accept ? 1 : 0)));
    if (accept) checkAt(idx, 8'hFF, 1'b0, 1'b1, 1'b1, {req, " ones"});
  endtask

  task automatic runAll();
    int seed;
    // reset state
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(rxValid), 0);
    chk("R1 data in reset", 32'({rxData, rxParErr, rxFrameErr, rxBreak}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 32'(rxValid), 0);
    chk("R1 data after reset", 32'({rxData, rxParErr, rxFrameErr, rxBreak}), 0);
    holdLine(1'b1, 40);

    // start-bit validation, 8-bit word, no parity
    wordLen = 2'd3; parEn = 1'b0; stop2 = 1'b0;
    osr8x = 1'b0;
    startPulse(6, 1'b0, "R2 16x short pulse rejected");
    startPulse(10, 1'b1, "R2 16x long pulse accepted");
    frameCheck(8'hA7, 1'b0, 1'b1, 1'b1, "R2 frame after false start");
    osr8x = 1'b1;
    startPulse(2, 1'b0, "R2 8x short pulse rejected");
    startPulse(6, 1'b1, "R2 8x mid-bit offset");

    // full configuration sweep
    seed = 0;
    for (int o = 0; o < 2; o++)
      for (int w = 0; w < 4; w++)
        for (int p = 0; p < 3; p++)
          for (int s = 0; s < 2; s++) begin
            osr8x = o[0]; wordLen = w[1:0];
            parEn = (p != 0); parOdd = (p == 2); stop2 = s[0];
            holdLine(1'b1, bitClk());
            seed++;
            frameCheck(8'(seed * 73 + 29), 1'b0, 1'b1, 1'b1, "R3 pattern a");
            frameCheck(~8'(seed * 73 + 29), 1'b0, 1'b1, 1'b1, "R3 pattern b");
            if (parEn) frameCheck(8'(seed * 41 + 3), 1'b1, 1'b1, 1'b1, "R4 bad parity");
            else frameCheck(8'(seed * 41 + 3), 1'b0, 1'b1, 1'b1, "R4 no parity");
            frameCheck(8'(seed * 17 + 1) | 8'h01, 1'b0, 1'b0, 1'b1, "R5 low stop");
            if (stop2) frameCheck(8'h5A, 1'b0, 1'b1, 1'b0, "R5 low second stop");
            breakCheck();
          end

    // back-to-back exhaustive 5-bit sweep, 8x, even parity
    osr8x = 1'b1; wordLen = 2'd0; parEn = 1'b1; parOdd = 1'b0; stop2 = 1'b0;
    holdLine(1'b1, bitClk());
    begin
      int base;
      base = validCount;
      for (int v = 0; v < 32; v++) sendFrame(8'(v), 1'b0, 1'b1, 1'b1, 0);
      holdLine(1'b1, bitClk());
      #1;
      chk("R10 back-to-back count", 32'(validCount), 32'(base + 32));
      for (int v = 0; v < 32; v++) checkAt(base + v, 8'(v), 1'b0, 1'b1, 1'b1, "R10 back-to-back");
    end

    // slower tick spacing
    tickDiv = 3;
    osr8x = 1'b0; wordLen = 2'd3; parEn = 1'b1; parOdd = 1'b1; stop2 = 1'b1;
    holdLine(1'b1, 3 * bitClk());
    frameCheck(8'hC3, 1'b0, 1'b1, 1'b1, "R9 tick every third clock 16x");
    osr8x = 1'b1;
    frameCheck(8'h3C, 1'b1, 1'b1, 1'b1, "R9 tick every third clock 8x");
    startPulse(3, 1'b0, "R9 short pulse with slow ticks");
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (190000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule